// File: doc/BRIEF.md
# Right-to-Left Modular Exponentiation Engine

This block raises a base to a power modulo a modulus, c^d mod n, on 32-bit operands by walking the exponent from its lowest bit upward. It keeps two registers: a running power of the base, squared once per exponent bit, and an accumulator that takes in that running power whenever the current exponent bit is set. A single bit-serial modular multiplier does all the arithmetic. The conditional product and the squaring for a bit therefore run back to back.

A host presents the operands together with a one-cycle `start` while `ready` is high. The engine stores the operands and drops `ready`. When the highest set exponent bit has been processed, it pulses `done` for one cycle with the result on `result`. Because the scan stops early, the run time depends on where the top set bit of the exponent lies.

The `HARDEN` parameter turns on a mode that issues a multiply even for a zero exponent bit and then discards the product. In that mode the cost of every bit is the same, and the run time reveals only the position of the top set bit.

Top module: `modexp_r2l`

## Requirements
- R1: During and after reset, with no start, `ready` is 1 and `done` is 0.
- R2: A `start` seen while `ready` is 1 is accepted, and `ready` is 0 from the next cycle until the end of the run. A `start` while `ready` is 0 is ignored.
- R3: `done` is high for exactly one cycle and `result` is valid in that cycle. `ready` is 1 in the cycle after `done`.
- R4: For 1 ≤ n and c < n, `result` equals c^d mod n in both modes.
- R5: With HARDEN=0, let p be the 1-based index of the highest set bit of d and m the number of set bits. `done` is high at the L-th rising edge counted from the accepting edge, where L = 1 + p·(W+1) + m·W.
- R6: With HARDEN=1, the latency is L = 1 + p·(2W+1). It does not depend on how many exponent bits are set.
- R7: For d = 0 and n > 1, the result is 1 with latency 1, and no multiply is done.
- R8: For n = 1, the result is 0 for any exponent.
- R9: The operand inputs are sampled only on the accepting edge. Changing them during a run does not alter the result.
- R10: Every result is less than the captured modulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a computation (taken when ready) |
| base_i | input | W | Base c, must be below n |
| exp_i | input | W | Exponent d |
| mod_i | input | W | Modulus n, nonzero |
| ready | output | 1 | Idle and able to take a start |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | c^d mod n, valid while done is high |

## Verification
A plain and a hardened instance get identical operands, and their results and cycle counts are compared against a reference power function and closed-form latency formulas. Random exponents with scattered set bits separate the two latency laws. Directed cases cover a zero exponent, a lone top bit, an all-ones exponent, a unit modulus, a zero base, a base of n−1 and a full-range modulus; they test the early exit, the worst-case run and the reduction edges. Throughout each run, the inputs are scrambled and spurious starts are pulsed, so that any late sampling of the operands or any restart while busy shows up as a wrong result or a wrong latency.

// File: rtl/modexp_r2l.sv
module modexp_r2l #(
  parameter int W      = 32,
  parameter int HARDEN = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] exp_i,
  input  logic [W-1:0] mod_i,
  output logic         ready,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  typedef enum logic [1:0] {S_IDLE, S_CHK, S_MUL, S_SQR} st_t;

  st_t           st;
  logic [W-1:0]  acc, sq, key, nreg, part;
  logic [CW-1:0] cnt;

  logic          last, use_mul, bbit;
  logic [W-1:0]  mul_b, nxt;
  logic [W+1:0]  t1, t1r, t2, nx;

  assign last    = (cnt == '0);
  assign use_mul = key[0] | (HARDEN != 0);
  assign mul_b   = (st == S_MUL) ? acc : sq;
  assign bbit    = mul_b[cnt];

  assign nx  = {2'b00, nreg};
  assign t1  = {1'b0, part, 1'b0};
  assign t1r = (t1 >= nx) ? t1 - nx : t1;
  assign t2  = t1r + {2'b00, sq & {W{bbit}}};
  assign nxt = (t2 >= nx) ? W'(t2 - nx) : W'(t2);

  assign ready  = (st == S_IDLE);
  assign done   = (st == S_CHK) && (key == '0);
  assign result = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      acc  <= '0;
      sq   <= '0;
      key  <= '0;
      nreg <= '0;
      part <= '0;
      cnt  <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          nreg <= mod_i;
          key  <= exp_i;
          sq   <= base_i;
          acc  <= (mod_i == W'(1)) ? '0 : W'(1);
          st   <= S_CHK;
        end
        S_CHK: begin
          part <= '0;
          cnt  <= CW'(W-1);
          if (key == '0)   st <= S_IDLE;
          else if (use_mul) st <= S_MUL;
          else             st <= S_SQR;
        end
        S_MUL: begin
          if (last) begin
            part <= '0;
            cnt  <= CW'(W-1);
            if (key[0]) acc <= nxt;
            st   <= S_SQR;
          end else begin
            part <= nxt;
            cnt  <= cnt - 1'b1;
          end
        end
        S_SQR: begin
          part <= nxt;
          cnt  <= cnt - 1'b1;
          if (last) begin
            sq  <= nxt;
            key <= key >> 1;
            st  <= S_CHK;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/modexp_r2l_chk.sv
module modexp_r2l_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         ready,
  input logic         done,
  input logic [W-1:0] result,
  input logic [W-1:0] nreg
);
  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && ready |=> !ready);

  // R3
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ready);

  // R2
  no_done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !done);

  // R8
  unit_modulus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (nreg == W'(1)) |-> result == '0);

  // R10
  result_below_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> result < nreg);
endmodule

bind modexp_r2l modexp_r2l_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
  .done(done), .result(result), .nreg(nreg)
);

// File: tb/modexp_r2l_tb_top.sv
module modexp_r2l_tb_top;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] base_v = '0, exp_v = '0, mod_v = '0;
  logic rdy_n, don_n, rdy_h, don_h;
  logic [W-1:0] res_n, res_h;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  modexp_r2l #(.W(W), .HARDEN(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .base_i(base_v), .exp_i(exp_v),
    .mod_i(mod_v), .ready(rdy_n), .done(don_n), .result(res_n));

  modexp_r2l #(.W(W), .HARDEN(1)) dut_h (
    .clk(clk), .rst_n(rst_n), .start(start), .base_i(base_v), .exp_i(exp_v),
    .mod_i(mod_v), .ready(rdy_h), .done(don_h), .result(res_h));

  function automatic logic [W-1:0] ref_pow(input logic [W-1:0] c, d, n);
    longint unsigned r, s, m;
    if (n == 1) return '0;
    m = longint'(n);
    r = 1;
    s = longint'(c);
    for (int k = 0; k < W; k++) begin
      if (d[k]) r = (r * s) % m;
      s = (s * s) % m;
    end
    return r[W-1:0];
  endfunction

  function automatic int ref_lat(input logic [W-1:0] d, input bit hard);
    int p = 0, m = 0;
    for (int k = 0; k < W; k++) if (d[k]) begin p = k + 1; m++; end
    return hard ? 1 + p * (2 * W + 1) : 1 + p * (W + 1) + m * W;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic [W-1:0] c, d, n);
    int lat, ln, lh;
    bit gn, gh;
    logic [W-1:0] er;
    er = ref_pow(c, d, n);
    ln = ref_lat(d, 0);
    lh = ref_lat(d, 1);
    @(negedge clk);
    base_v = c; exp_v = d; mod_v = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1; gn = 0; gh = 0;
    if (lh > 1) chk(!rdy_h, "R2 ready low after accept", rdy_h, 0);
    while (!(gn && gh)) begin
      if (!gn && don_n) begin
        gn = 1;
        chk(res_n == er, "R4 R9 result (plain)", res_n, er);
        chk(lat == ln, "R5 latency (plain)", lat, ln);
        chk(res_n < n, "R10 result below modulus", res_n, n);
        if (d == 0 && n > 1) chk(res_n == 1 && lat == 1, "R7 zero exponent", res_n, 1);
        if (n == 1) chk(res_n == 0, "R8 unit modulus", res_n, 0);
      end
      if (!gh && don_h) begin
        gh = 1;
        chk(res_h == er, "R4 R9 result (hardened)", res_h, er);
        chk(lat == lh, "R6 latency (hardened)", lat, lh);
      end
      if (!(gn && gh)) begin
        base_v = $urandom; exp_v = $urandom; mod_v = $urandom;
        start = (!rdy_n && !rdy_h && ($urandom % 4 == 0));
        @(negedge clk);
        lat++;
        if (lat > 5000) begin
          chk(0, "R3 run never finished", lat, lh);
          break;
        end
      end
    end
    start = 1'b0;
    @(negedge clk);
    chk(rdy_n && rdy_h, "R3 ready after done", {rdy_n, rdy_h}, 3);
    chk(!don_n && !don_h, "R3 done is one pulse", {don_n, don_h}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] n, c;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(rdy_n && rdy_h && !don_n && !don_h, "R1 state in reset", {rdy_n, don_n}, 2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(rdy_n && rdy_h && !don_n && !don_h, "R1 state after reset", {rdy_n, don_n}, 2);

    run(32'd5, 32'd0, 32'd97);
    run(32'd0, 32'hDEAD_BEEF, 32'd1);
    run(32'd0, 32'd0, 32'd1);
    run(32'd7, 32'd1, 32'd13);
    run(32'd3, 32'h8000_0000, 32'hFFFF_FFFB);
    run(32'h1234_5678, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run(32'd0, 32'd77, 32'd1009);
    run(32'd1008, 32'd3, 32'd1009);
    run(32'hFFFF_FFFE, 32'h0001_0001, 32'hFFFF_FFFF);
    run(32'd2, 32'd10, 32'd2);

    for (int i = 0; i < 30; i++) begin
      n = $urandom;
      if (n == 0) n = 32'd3;
      c = $urandom % n;
      run(c, $urandom >> ($urandom % 24), n);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule